// File: doc/BRIEF.md
# Branch-Aware Control and Next-PC Unit

This block holds the decode, ALU and program-counter logic of a single-cycle 32-bit core that runs register-register arithmetic, word loads and stores, and two conditional branches: branch-if-equal and branch-if-not-equal. A main decoder turns the opcode into a two-bit ALU operation class; a second decoder turns the class, and for register-register instructions the funct field, into a four-bit ALU code. The ALU result and its zero flag then decide whether the program counter follows a branch.

Branch-if-not-equal has no control line of its own. It takes the class value 11, which no other instruction uses. That class maps to an ALU code which subtracts like the ordinary subtract code. The taken condition is both class bits ANDed with the inverted zero flag. This term is ORed with the branch-if-equal term (branch line AND zero) to drive one PC-source select. The register file and the memories live outside the block. The bench drives the two register operands directly, and the PC register sits inside the block.

Top module: `branch_npc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the PC register is loaded with 0.
- R2: Opcode 000000 gives class 10, and the ALU code comes from funct: 100000→0010 (add), 100010→0110 (subtract), 100100→0000 (and), 100101→0001 (or), 101010→0111 (set-less-than).
- R3: Opcodes 100011 and 101011 give class 00 and code 0010. The ALU result is `rs_val` plus the sign-extended 16-bit immediate.
- R4: Opcode 000100 gives class 01 and code 0110, and the result is `rs_val - rt_val`.
- R5: Opcode 000101 gives class 11 and code 1110. The result is the same `rs_val - rt_val` that code 0110 gives.
- R6: `zero` is 1 exactly when the ALU result is all zeros. For both branches, this means exactly when the two operands are equal.
- R7: `pc_sel` is 1 for opcode 000100 with equal operands and for opcode 000101 with unequal operands, and 0 otherwise.
- R8: When `pc_sel` is 1, `pc_next` is PC+4 plus the sign-extended immediate shifted left by 2. Negative offsets go backwards.
- R9: When `pc_sel` is 0, `pc_next` is PC+4. Once out of reset, each rising edge loads `pc_next` into the PC.
- R10: Set-less-than compares the operands as signed numbers and returns 1 or 0 in the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the PC |
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction funct field |
| imm | input | 16 | Instruction immediate / branch offset |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| alu_class | output | 2 | ALU operation class from the main decoder |
| alu_code | output | 4 | ALU control code |
| alu_result | output | 32 | ALU result |
| zero | output | 1 | ALU result is all zeros |
| pc_sel | output | 1 | Branch taken, selects the branch target |
| pc | output | 32 | Current PC register value |
| pc_next | output | 32 | Value loaded into the PC at the next edge |

## Verification
The hard case is a branch whose outcome depends on the operands rather than on the opcode. The same opcode has to be seen both taken and falling through, and a branch-not-equal must not be steered by the branch-if-equal term. The stimulus therefore sends each branch opcode twice in a row, once with equal and once with unequal operands. It uses forward and backward offsets, so a taken branch moves the PC and later items start from a non-sequential address. A synchronous reset in the middle of the run checks that the PC restarts from zero after such jumps.

// File: rtl/bnpc_pkg.sv
// Package: shared opcodes, ALU class and ALU code encodings for the
// branch-aware control and next-PC unit. Assumes 6-bit opcode/funct fields.
package bnpc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BREQ  = 6'b000100;
    localparam logic [5:0] OP_BRNE  = 6'b000101;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_MEM   = 2'b00,
        CLS_EQ    = 2'b01,
        CLS_FUNCT = 2'b10,
        CLS_NE    = 2'b11
    } alu_class_e;

    typedef enum logic [3:0] {
        AC_AND   = 4'b0000,
        AC_OR    = 4'b0001,
        AC_ADD   = 4'b0010,
        AC_SUB   = 4'b0110,
        AC_SLT   = 4'b0111,
        AC_SUBNE = 4'b1110
    } alu_code_e;

endpackage

// File: rtl/bnpc_main_dec.sv
// Main decoder: maps the opcode to an ALU class, the branch-if-equal line
// and the immediate-operand select. Branch-if-not-equal is signalled only by
// class 11; the branch line stays low for it. Unknown opcodes act like class 00
// with register operands and no branch.
module bnpc_main_dec
    import bnpc_pkg::*;
(
    input  logic [5:0]  opcode,
    output alu_class_e  cls,
    output logic        branch,
    output logic        use_imm
);

    // Opcode to control line decode.
    always_comb begin
        cls     = CLS_MEM;
        branch  = 1'b0;
        use_imm = 1'b0;
        case (opcode)
            OP_RTYPE: cls = CLS_FUNCT;
            OP_LOAD,
            OP_STORE: use_imm = 1'b1;
            OP_BREQ: begin
                cls    = CLS_EQ;
                branch = 1'b1;
            end
            OP_BRNE:  cls = CLS_NE;
            default:  cls = CLS_MEM;
        endcase
    end

endmodule

// File: rtl/bnpc_alu_ctrl.sv
// ALU control decoder: turns the ALU class and funct field into a 4-bit ALU
// code. Class 11 yields the not-equal subtract code. Unlisted funct values
// fall back to add.
module bnpc_alu_ctrl
    import bnpc_pkg::*;
(
    input  alu_class_e  cls,
    input  logic [5:0]  funct,
    output alu_code_e   code
);

    // Class and funct to ALU code decode.
    always_comb begin
        unique case (cls)
            CLS_MEM: code = AC_ADD;
            CLS_EQ:  code = AC_SUB;
            CLS_NE:  code = AC_SUBNE;
            default: begin
                case (funct)
                    FN_SUB:  code = AC_SUB;
                    FN_AND:  code = AC_AND;
                    FN_OR:   code = AC_OR;
                    FN_SLT:  code = AC_SLT;
                    default: code = AC_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/bnpc_alu.sv
// ALU: add, subtract (two codes), and, or and signed set-less-than on W-bit
// operands, plus an all-zeros flag. Unlisted codes give a zero result.
module bnpc_alu
    import bnpc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_code_e     code,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  result,
    output logic          zero
);

    // Operation select.
    always_comb begin
        case (code)
            AC_ADD:   result = a + b;
            AC_SUB,
            AC_SUBNE: result = a - b;
            AC_AND:   result = a & b;
            AC_OR:    result = a | b;
            AC_SLT:   result = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default:  result = '0;
        endcase
    end

    // All-zeros flag of the result.
    always_comb zero = (result == '0);

endmodule

// File: rtl/bnpc_pc.sv
// PC unit: holds the PC register and forms PC+4 and the branch target
// PC+4 + (offset << 2). The offset arrives already sign-extended to W bits.
// The register resets synchronously to 0.
module bnpc_pc #(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  offset,
    input  logic          take,
    output logic [W-1:0]  pc_q,
    output logic [W-1:0]  pc_nxt
);

    localparam logic [W-1:0] STEP = W'(4);

    logic [W-1:0] pc_seq;
    logic [W-1:0] pc_tgt;

    // Sequential and branch target addresses.
    always_comb begin
        pc_seq = pc_q + STEP;
        pc_tgt = pc_seq + (offset << 2);
        pc_nxt = take ? pc_tgt : pc_seq;
    end

    // PC register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    // R9: once out of reset the PC follows the previous next-PC.
    assert_pc_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc_q == $past(pc_nxt));

    // R9: a not-taken cycle falls through to PC+4.
    assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> pc_nxt == pc_q + STEP);

endmodule

// File: rtl/branch_npc_unit.sv
// Top: control, ALU and next-PC logic of a single-cycle core. It branches on
// equal (branch line AND zero) or on not-equal (both class bits AND NOT zero)
// through one PC-source select. Assumes operands come from an external
// register file, driven straight onto rs_val / rt_val.
module branch_npc_unit
    import bnpc_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        opcode,
    input  logic [5:0]        funct,
    input  logic [IMM_W-1:0]  imm,
    input  logic [W-1:0]      rs_val,
    input  logic [W-1:0]      rt_val,
    output logic [1:0]        alu_class,
    output logic [3:0]        alu_code,
    output logic [W-1:0]      alu_result,
    output logic              zero,
    output logic              pc_sel,
    output logic [W-1:0]      pc,
    output logic [W-1:0]      pc_next
);

    alu_class_e   cls;
    alu_code_e    code;
    logic         branch;
    logic         use_imm;
    logic [W-1:0] imm_ext;
    logic [W-1:0] op_b;
    logic         take_eq;
    logic         take_ne;

    bnpc_main_dec u_dec (
        .opcode  (opcode),
        .cls     (cls),
        .branch  (branch),
        .use_imm (use_imm)
    );

    bnpc_alu_ctrl u_actl (
        .cls   (cls),
        .funct (funct),
        .code  (code)
    );

    // Immediate sign extension and second operand select.
    always_comb begin
        imm_ext = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
        op_b    = use_imm ? imm_ext : rt_val;
    end

    bnpc_alu #(.W(W)) u_alu (
        .code   (code),
        .a      (rs_val),
        .b      (op_b),
        .result (alu_result),
        .zero   (zero)
    );

    // PC-source select: equal term ORed with the class-11 not-equal term.
    always_comb begin
        take_eq = branch & zero;
        take_ne = cls[1] & cls[0] & ~zero;
        pc_sel  = take_eq | take_ne;
    end

    bnpc_pc #(.W(W)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .offset (imm_ext),
        .take   (pc_sel),
        .pc_q   (pc),
        .pc_nxt (pc_next)
    );

    // Export decoded class and code as plain vectors.
    always_comb begin
        alu_class = cls;
        alu_code  = code;
    end

    // R5: not-equal branch opcode gives class 11 and code 1110.
    assert_brne_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == OP_BRNE |-> (alu_class == 2'b11 && alu_code == 4'b1110));

    // R6: on either branch the zero flag reports operand equality.
    assert_zero_eq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_BREQ || opcode == OP_BRNE) |-> zero == (rs_val == rt_val));

    // R7: a taken branch needs a branch opcode with the matching comparison.
    assert_taken_cond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel |-> ((opcode == OP_BREQ && rs_val == rt_val) ||
                    (opcode == OP_BRNE && rs_val != rt_val)));

    // R4: equal-branch opcode gives class 01 and code 0110.
    assert_breq_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        opcode == OP_BREQ |-> (alu_class == 2'b01 && alu_code == 4'b0110));

endmodule

// File: tb/branch_npc_unit_tb.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and
// compares them half a cycle later.
module branch_npc_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = 6'b100011;
    logic [5:0]  funct = 6'b0;
    logic [15:0] imm = 16'h0;
    logic [31:0] rs_val = 32'h0;
    logic [31:0] rt_val = 32'h0;
    logic [1:0]  alu_class;
    logic [3:0]  alu_code;
    logic [31:0] alu_result;
    logic        zero;
    logic        pc_sel;
    logic [31:0] pc;
    logic [31:0] pc_next;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_pc = 32'h0;

    typedef struct {
        string       tag;
        logic [1:0]  cls;
        logic [3:0]  code;
        logic [31:0] res;
        logic        z;
        logic        sel;
        logic [31:0] cur;
        logic [31:0] nxt;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_npc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .imm(imm),
        .rs_val(rs_val), .rt_val(rt_val), .alu_class(alu_class),
        .alu_code(alu_code), .alu_result(alu_result), .zero(zero),
        .pc_sel(pc_sel), .pc(pc), .pc_next(pc_next)
    );

    // Expected outputs from the requirement text.
    function automatic exp_t predict(string tag, logic [5:0] op, logic [5:0] fn,
                                     logic [15:0] im, logic [31:0] a,
                                     logic [31:0] b, logic [31:0] cur);
        exp_t e;
        logic [31:0] sx;
        logic [31:0] bb;
        sx = {{16{im[15]}}, im};
        bb = b;
        e.tag = tag;
        e.cur = cur;
        case (op)
            6'b000000: begin
                e.cls = 2'b10;
                case (fn)
                    6'b100010: e.code = 4'b0110;
                    6'b100100: e.code = 4'b0000;
                    6'b100101: e.code = 4'b0001;
                    6'b101010: e.code = 4'b0111;
                    default:   e.code = 4'b0010;
                endcase
            end
            6'b100011, 6'b101011: begin e.cls = 2'b00; e.code = 4'b0010; bb = sx; end
            6'b000100: begin e.cls = 2'b01; e.code = 4'b0110; end
            6'b000101: begin e.cls = 2'b11; e.code = 4'b1110; end
            default:   begin e.cls = 2'b00; e.code = 4'b0010; end
        endcase
        case (e.code)
            4'b0010: e.res = a + bb;
            4'b0110, 4'b1110: e.res = a - bb;
            4'b0000: e.res = a & bb;
            4'b0001: e.res = a | bb;
            4'b0111: e.res = ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
            default: e.res = 32'd0;
        endcase
        e.z   = (e.res == 32'd0);
        e.sel = (op == 6'b000100 && a == b) || (op == 6'b000101 && a != b);
        e.nxt = e.sel ? (cur + 32'd4 + (sx << 2)) : (cur + 32'd4);
        return e;
    endfunction

    // Driver: apply one instruction, push its expectation, step one edge.
    task automatic drive(string tag, logic [5:0] op, logic [5:0] fn,
                         logic [15:0] im, logic [31:0] a, logic [31:0] b);
        exp_t e;
        opcode = op; funct = fn; imm = im; rs_val = a; rt_val = b;
        e = predict(tag, op, fn, im, a, b, model_pc);
        sb.push_back(e);
        @(posedge clk);
        #1;
        model_pc = e.nxt;
    endtask

    // Monitor: pop and compare at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (alu_class !== e.cls || alu_code !== e.code || alu_result !== e.res ||
                    zero !== e.z || pc_sel !== e.sel || pc !== e.cur || pc_next !== e.nxt) begin
                    failures++;
                    $display("FAIL %s: got cls=%b code=%b res=%h z=%b sel=%b pc=%h nxt=%h exp cls=%b code=%b res=%h z=%b sel=%b pc=%h nxt=%h",
                             e.tag, alu_class, alu_code, alu_result, zero, pc_sel, pc, pc_next,
                             e.cls, e.code, e.res, e.z, e.sel, e.cur, e.nxt);
                end
            end
        end
    end

    task automatic check_reset(string tag);
        checks++;
        if (pc !== 32'h0) begin
            failures++;
            $display("FAIL %s: pc=%h exp=%h", tag, pc, 32'h0);
        end
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog: run did not finish, got timeout exp completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset("R1 initial reset");
        rst_n = 1'b1;
        model_pc = 32'h0;

        drive("R2 add",       6'b000000, 6'b100000, 16'h0, 32'd25, 32'd17);
        drive("R2 sub",       6'b000000, 6'b100010, 16'h0, 32'd5, 32'd9);
        drive("R2 and",       6'b000000, 6'b100100, 16'h0, 32'hF0F0_1234, 32'h0FF0_FF00);
        drive("R2 or",        6'b000000, 6'b100101, 16'h0, 32'hF000_0001, 32'h0000_1000);
        drive("R10 slt neg",  6'b000000, 6'b101010, 16'h0, 32'hFFFF_FFFE, 32'd3);
        drive("R10 slt pos",  6'b000000, 6'b101010, 16'h0, 32'd3, 32'hFFFF_FFFE);
        drive("R6 sub zero",  6'b000000, 6'b100010, 16'h0, 32'd77, 32'd77);
        drive("R3 load",      6'b100011, 6'b0, 16'h0010, 32'h1000, 32'hDEAD);
        drive("R3 store neg", 6'b101011, 6'b0, 16'hFFF8, 32'h2000, 32'hBEEF);
        drive("R4 R8 beq taken",    6'b000100, 6'b0, 16'h0005, 32'h1234, 32'h1234);
        drive("R4 R9 beq not taken",6'b000100, 6'b0, 16'h0005, 32'h1234, 32'h1235);
        drive("R5 R7 bne taken back", 6'b000101, 6'b0, 16'hFFFC, 32'd1, 32'd2);
        drive("R5 R9 bne equal falls",6'b000101, 6'b0, 16'h0040, 32'd9, 32'd9);
        drive("R7 bne funct ignored", 6'b000101, 6'b100100, 16'h0002, 32'h8000_0000, 32'h0);
        drive("R7 beq zero ops",      6'b000100, 6'b0, 16'hFFFF, 32'h0, 32'h0);
        drive("R9 add after jumps",   6'b000000, 6'b100000, 16'h0, 32'd1, 32'd1);

        // Mid-run synchronous reset.
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_reset("R1 mid-run reset");
        rst_n = 1'b1;
        model_pc = 32'h0;
        drive("R8 R1 branch after reset", 6'b000101, 6'b0, 16'h0003, 32'd4, 32'd5);
        drive("R9 sequential",            6'b100011, 6'b0, 16'h0004, 32'd8, 32'd0);

        @(negedge clk);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule